// File: doc/BRIEF.md
# Shared-Phasor Frequency Offset Rotator

This block removes a residual carrier frequency offset from a complex baseband stream that arrives four samples per clock on a quarter-rate clock. It keeps a single phase register and a single sine/cosine lookup. Each clock they produce one rotation phasor, and that phasor is applied to all four lanes of the beat through four complex multipliers. Rotating four neighbouring samples by one shared angle is an approximation. It is accepted because the residual offset is small, and in exchange the phase-to-phasor path is not replicated.

The lookup stores cosine and sine side by side for one octant only. A quadrant and octant fold produces the full circle: the octant bit reflects the table index and, together with the low quadrant bit, decides whether the two outputs are exchanged; the quadrant then fixes the two signs. A frequency estimator elsewhere in the receiver supplies the per-sample phase increment. A clear strobe restarts the phase at zero, for example at a new packet.

Top module: `cfo_shared_rotator`

## Requirements
- R1: While reset is held and in the first cycle after it, out_valid is 0, every output lane reads 0, and the phase register holds 0.
- R2: out_valid rises exactly two clock edges after the edge that captures in_valid high, and it is low for every beat that was not valid.
- R3: Each valid beat that is not cleared advances the 12-bit phase register by 4*phase_inc modulo 4096. Beats with in_valid low leave it unchanged.
- R4: When phase_clr is high, that beat is rotated by phase 0, and the register afterwards holds 4*phase_inc if in_valid is high, else 0.
- R5: All four lanes of a beat use one phasor (C,S) taken at the negated beat phase. Each output is yI = I*C + Q*S and yQ = Q*C - I*S, with I/Q as signed 8-bit values.
- R6: With a = (4096 - phase) mod 4096, quadrant = a[11:10], octant bit = a[9] and index k = a[8:3], inverted to 63-k when the octant bit is 1. Table entry k holds round(1023*cos(k*pi/256)) and round(1023*sin(k*pi/256)).
- R7: The cosine magnitude is taken from the sine entry, and the sine magnitude from the cosine entry, exactly when octant bit XOR a[10] is 1. C is negative in quadrants 1 and 2, and S is negative in quadrants 2 and 3.
- R8: Each product sum is rounded as floor((sum + 512) / 1024) and saturated to the range -128..127.
- R9: Whenever out_valid is low, the output lanes keep the values they last held.
- R10: Lane n occupies bits [8n+7:8n] of in_i, in_q, out_i and out_q, and lane 0 is the earliest sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Quarter-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_inc | input | 12 | Per-sample phase step, 4096 codes per turn |
| phase_clr | input | 1 | Restart the phase at zero for this beat |
| in_valid | input | 1 | Input beat qualifier |
| in_i | input | 32 | Four signed 8-bit in-phase lanes |
| in_q | input | 32 | Four signed 8-bit quadrature lanes |
| out_valid | output | 1 | Output beat qualifier |
| out_i | output | 32 | Four rotated in-phase lanes |
| out_q | output | 32 | Four rotated quadrature lanes |

## Verification
On every cycle, the assertions check the two-edge valid latency, the phase register's advance, hold and clear rules, and that the outputs are held while out_valid is low. The arithmetic itself can only be shown by the bench scenarios: the octant fold with index inversion and swap, the quadrant signs, the rounding and the saturation. The bench shows them through an exhaustive sweep of all 65536 I/Q input pairs at phase zero and a walk over every table position in all eight octants, with saturating corner inputs mixed in.

// File: rtl/cfo_rot_pkg.sv
package cfo_rot_pkg;

    localparam real PI_R = 3.14159265358979323846;

    // One octant table entry: cosine (want_sin=0) or sine of k*(pi/4)/2^aw,
    // scaled to the full unsigned magnitude range and rounded.
    function automatic int octant_entry(input int k, input int aw, input int mw,
                                        input bit want_sin);
        real th;
        real v;
        th = (real'(k) * PI_R) / (4.0 * real'(1 << aw));
        v  = want_sin ? $sin(th) : $cos(th);
        return $rtoi(v * real'((1 << mw) - 1) + 0.5);
    endfunction

endpackage

// File: rtl/cfo_phase_acc.sv
module cfo_phase_acc #(
    parameter int PW    = 12,
    parameter int LANES = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          adv,
    input  logic [PW-1:0] inc,
    output logic [PW-1:0] phase_use,
    output logic [PW-1:0] phase_q
);

    localparam logic [PW-1:0] STEP_MUL = PW'(LANES);

    typedef struct packed {
        logic [PW-1:0] ph;
    } acc_t;

    acc_t st_d, st_q;

    always_comb begin
        phase_use = clr ? '0 : st_q.ph;
        st_d.ph   = phase_use + (adv ? PW'(inc * STEP_MUL) : '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign phase_q = st_q.ph;

endmodule

// File: rtl/cfo_phasor_rom.sv
module cfo_phasor_rom #(
    parameter int PW = 12,
    parameter int AW = 6,
    parameter int MW = 10
) (
    input  logic [PW-1:0]        phase,
    output logic signed [MW:0]   cos_o,
    output logic signed [MW:0]   sin_o
);

    localparam int DEPTH = 1 << AW;
    localparam int TW    = AW + 3;   // quadrant(2) + octant(1) + index

    logic [MW-1:0] cos_rom [DEPTH];
    logic [MW-1:0] sin_rom [DEPTH];

    for (genvar k = 0; k < DEPTH; k++) begin : g_rom
        localparam int CV = cfo_rot_pkg::octant_entry(k, AW, MW, 1'b0);
        localparam int SV = cfo_rot_pkg::octant_entry(k, AW, MW, 1'b1);
        assign cos_rom[k] = MW'(CV);
        assign sin_rom[k] = MW'(SV);
    end

    logic [TW-1:0] ang;
    logic [1:0]    quad;
    logic          oct;
    logic [AW-1:0] idx;
    logic          swap;
    logic [MW-1:0] c_mag, s_mag;
    logic          c_neg, s_neg;

    always_comb begin
        // rotation is by the negated accumulated phase
        ang   = TW'((PW'(0) - phase) >> (PW - TW));
        quad  = ang[TW-1:TW-2];
        oct   = ang[TW-3];
        idx   = oct ? ~ang[AW-1:0] : ang[AW-1:0];
        swap  = oct ^ quad[0];
        c_mag = swap ? sin_rom[idx] : cos_rom[idx];
        s_mag = swap ? cos_rom[idx] : sin_rom[idx];
        c_neg = quad[1] ^ quad[0];
        s_neg = quad[1];
        cos_o = c_neg ? -$signed({1'b0, c_mag}) : $signed({1'b0, c_mag});
        sin_o = s_neg ? -$signed({1'b0, s_mag}) : $signed({1'b0, s_mag});
    end

endmodule

// File: rtl/cfo_lane_rot.sv
module cfo_lane_rot #(
    parameter int DW = 8,
    parameter int MW = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic signed [DW-1:0] x_i,
    input  logic signed [DW-1:0] x_q,
    input  logic signed [MW:0]   c,
    input  logic signed [MW:0]   s,
    output logic signed [DW-1:0] y_i,
    output logic signed [DW-1:0] y_q
);

    localparam int SW = DW + MW + 2;
    localparam logic signed [SW-1:0] HALF = SW'(1) << (MW - 1);
    localparam logic signed [SW-1:0] MAXV = SW'((1 << (DW - 1)) - 1);
    localparam logic signed [SW-1:0] MINV = -MAXV - SW'(1);

    typedef struct packed {
        logic [DW-1:0] yi;
        logic [DW-1:0] yq;
    } lane_t;

    lane_t st_d, st_q;

    function automatic logic [DW-1:0] rnd_sat(input logic signed [SW-1:0] v);
        logic signed [SW-1:0] r;
        r = (v + HALF) >>> MW;
        if (r > MAXV)      return MAXV[DW-1:0];
        else if (r < MINV) return MINV[DW-1:0];
        else               return r[DW-1:0];
    endfunction

    logic signed [SW-1:0] xi, xq, cs, ss, pi_sum, pq_sum;

    always_comb begin
        xi     = SW'(x_i);
        xq     = SW'(x_q);
        cs     = SW'(c);
        ss     = SW'(s);
        pi_sum = xi * cs + xq * ss;
        pq_sum = xq * cs - xi * ss;
        st_d   = st_q;
        if (en) begin
            st_d.yi = rnd_sat(pi_sum);
            st_d.yq = rnd_sat(pq_sum);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign y_i = $signed(st_q.yi);
    assign y_q = $signed(st_q.yq);

endmodule

// File: rtl/cfo_shared_rotator.sv
module cfo_shared_rotator #(
    parameter int LANES = 4,
    parameter int DW    = 8,
    parameter int PW    = 12,
    parameter int AW    = 6,
    parameter int MW    = 10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [PW-1:0]         phase_inc,
    input  logic                  phase_clr,
    input  logic                  in_valid,
    input  logic [LANES*DW-1:0]   in_i,
    input  logic [LANES*DW-1:0]   in_q,
    output logic                  out_valid,
    output logic [LANES*DW-1:0]   out_i,
    output logic [LANES*DW-1:0]   out_q
);

    typedef struct packed {
        logic                      vld;
        logic [LANES-1:0][DW-1:0]  li;
        logic [LANES-1:0][DW-1:0]  lq;
        logic [MW:0]               c;
        logic [MW:0]               s;
        logic                      ov;
    } pipe_t;

    pipe_t st_d, st_q;

    logic [PW-1:0]       phase_use;
    logic [PW-1:0]       acc_phase;
    logic signed [MW:0]  rom_cos, rom_sin;

    cfo_phase_acc #(.PW(PW), .LANES(LANES)) i_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (phase_clr),
        .adv       (in_valid),
        .inc       (phase_inc),
        .phase_use (phase_use),
        .phase_q   (acc_phase)
    );

    cfo_phasor_rom #(.PW(PW), .AW(AW), .MW(MW)) i_rom (
        .phase (phase_use),
        .cos_o (rom_cos),
        .sin_o (rom_sin)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        st_d.ov  = st_q.vld;
        if (in_valid) begin
            st_d.li = in_i;
            st_d.lq = in_q;
            st_d.c  = rom_cos;
            st_d.s  = rom_sin;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    logic signed [DW-1:0] lane_yi [LANES];
    logic signed [DW-1:0] lane_yq [LANES];

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        cfo_lane_rot #(.DW(DW), .MW(MW)) i_rot (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (st_q.vld),
            .x_i   ($signed(st_q.li[l])),
            .x_q   ($signed(st_q.lq[l])),
            .c     ($signed(st_q.c)),
            .s     ($signed(st_q.s)),
            .y_i   (lane_yi[l]),
            .y_q   (lane_yq[l])
        );
        assign out_i[l*DW +: DW] = lane_yi[l];
        assign out_q[l*DW +: DW] = lane_yq[l];
    end

    assign out_valid = st_q.ov;

endmodule

// File: rtl/cfo_shared_rotator_chk.sv
module cfo_shared_rotator_chk #(
    parameter int LANES = 4,
    parameter int DW    = 8,
    parameter int PW    = 12
) (
    input logic                clk,
    input logic                rst_n,
    input logic [PW-1:0]       phase_inc,
    input logic                phase_clr,
    input logic                in_valid,
    input logic [PW-1:0]       acc_phase,
    input logic                out_valid,
    input logic [LANES*DW-1:0] out_i,
    input logic [LANES*DW-1:0] out_q
);

    localparam logic [PW-1:0] MUL = PW'(LANES);

    // R2
    valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid, 2));

    // R3
    phase_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !phase_clr) |=> acc_phase == PW'($past(acc_phase) + $past(phase_inc) * MUL));

    // R3
    phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && !phase_clr) |=> $stable(acc_phase));

    // R4
    phase_clear_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_clr && !in_valid) |=> acc_phase == '0);

    // R4
    phase_clear_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_clr && in_valid) |=> acc_phase == PW'($past(phase_inc) * MUL));

    // R9
    output_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> ($stable(out_i) && $stable(out_q)));

endmodule

bind cfo_shared_rotator cfo_shared_rotator_chk #(
    .LANES (LANES),
    .DW    (DW),
    .PW    (PW)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase_inc (phase_inc),
    .phase_clr (phase_clr),
    .in_valid  (in_valid),
    .acc_phase (acc_phase),
    .out_valid (out_valid),
    .out_i     (out_i),
    .out_q     (out_q)
);

// File: tb/test_cfo_shared_rotator.sv
module test_cfo_shared_rotator;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] phase_inc = '0;
    logic        phase_clr = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_i = '0;
    logic [31:0] in_q = '0;
    logic        out_valid;
    logic [31:0] out_i, out_q;

    always #4 clk = ~clk;

    cfo_shared_rotator i_cfo_shared_rotator (
        .clk(clk), .rst_n(rst_n), .phase_inc(phase_inc), .phase_clr(phase_clr),
        .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
        .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    int ref_ph = 0;
    int exp_q[$];
    bit pend0 = 1'b0, pend1 = 1'b0;
    logic [31:0] last_i = '0, last_q = '0;
    int d_i[4];
    int d_q[4];

    localparam real PI_T = 3.14159265358979323846;

    // R6: entry magnitudes
    function automatic int tbl(int k, bit sn);
        real th = real'(k) * PI_T / 256.0;
        return $rtoi((sn ? $sin(th) : $cos(th)) * 1023.0 + 0.5);
    endfunction

    // R6, R7: phasor for the negated phase
    task automatic phasor(input int ph, output int c, output int s);
        int a, quad, oct, k, c0, s0, cm, sm;
        a    = (4096 - ph) % 4096;
        quad = a / 1024;
        oct  = (a / 512) % 2;
        k    = (a / 8) % 64;
        if (oct == 1) k = 63 - k;
        c0 = tbl(k, 1'b0);
        s0 = tbl(k, 1'b1);
        if ((oct ^ (quad % 2)) == 1) begin cm = s0; sm = c0; end
        else begin cm = c0; sm = s0; end
        c = (quad == 1 || quad == 2) ? -cm : cm;
        s = (quad >= 2) ? -sm : sm;
    endtask

    // R8
    function automatic int rs(int v);
        int r = (v + 512) >>> 10;
        if (r > 127) r = 127;
        if (r < -128) r = -128;
        return r;
    endfunction

    function automatic int sx8(logic [7:0] b);
        return int'($signed(b));
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_outputs();
        check("R2 out_valid", int'(out_valid), int'(pend1));
        if (out_valid) begin
            if (exp_q.size() < 8) begin
                check("R2 expected beat present", 0, 1);
            end else begin
                for (int l = 0; l < 4; l++) begin
                    int ei, eq;
                    ei = exp_q.pop_front();
                    eq = exp_q.pop_front();
                    // R5 R10 lane placement and rotation
                    check("R5 lane I", sx8(out_i[8*l +: 8]), ei);
                    check("R5 lane Q", sx8(out_q[8*l +: 8]), eq);
                end
            end
        end else begin
            check("R9 hold I", int'(out_i == last_i), 1);
            check("R9 hold Q", int'(out_q == last_q), 1);
        end
        last_i = out_i;
        last_q = out_q;
    endtask

    task automatic step(input bit v, input bit clr, input int inc);
        int use_ph, c, s;
        @(negedge clk);
        check_outputs();
        pend1 = pend0;
        pend0 = v;
        in_valid  = v;
        phase_clr = clr;
        phase_inc = 12'(inc);
        for (int l = 0; l < 4; l++) begin
            in_i[8*l +: 8] = 8'(d_i[l]);
            in_q[8*l +: 8] = 8'(d_q[l]);
        end
        use_ph = clr ? 0 : ref_ph;
        if (v) begin
            phasor(use_ph, c, s);
            for (int l = 0; l < 4; l++) begin
                exp_q.push_back(rs(d_i[l] * c + d_q[l] * s));
                exp_q.push_back(rs(d_q[l] * c - d_i[l] * s));
            end
        end
        ref_ph = (use_ph + (v ? 4 * inc : 0)) % 4096;
    endtask

    function automatic void pattern(int b);
        for (int l = 0; l < 4; l++) begin
            d_i[l] = ((b * 37 + l * 53) % 256) - 128;
            d_q[l] = ((b * 91 + l * 17 + 5) % 256) - 128;
            if (b % 8 == 3) begin d_i[l] = -128; d_q[l] = (l % 2 == 0) ? -128 : 127; end
            if (b % 8 == 6) begin d_i[l] = 127;  d_q[l] = (l % 2 == 0) ? 127 : -128; end
        end
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int l = 0; l < 4; l++) begin d_i[l] = 0; d_q[l] = 0; end
        repeat (3) @(negedge clk);
        // R1 during reset
        check("R1 out_valid in reset", int'(out_valid), 0);
        check("R1 out_i in reset", int'(out_i == 0), 1);
        check("R1 out_q in reset", int'(out_q == 0), 1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 out_valid after reset", int'(out_valid), 0);
        check("R1 out lanes after reset", int'((out_i | out_q) == 0), 1);

        // R6 R8 R10: exhaustive I/Q at phase 0 (clear on every beat, R4)
        for (int b = 0; b < 16384; b++) begin
            for (int l = 0; l < 4; l++) begin
                int n = b * 4 + l;
                d_i[l] = (n / 256) - 128;
                d_q[l] = (n % 256) - 128;
            end
            step(1'b1, 1'b1, 77);
        end

        // R3 R6 R7: phase walks every table position in all octants
        step(1'b1, 1'b1, 1);
        for (int b = 0; b < 1100; b++) begin
            pattern(b);
            step(1'b1, 1'b0, 1);
        end

        // R3: gaps hold the phase; larger step size
        for (int b = 0; b < 600; b++) begin
            pattern(b + 5);
            step((b % 3) != 1, 1'b0, 301 + b);
        end

        // R4: clear with and without a beat, mid-stream
        for (int b = 0; b < 200; b++) begin
            pattern(b * 7);
            step((b % 4) != 2, (b % 5) == 0, 1000 + 13 * b);
        end

        for (int b = 0; b < 4; b++) step(1'b0, 1'b0, 0);
        check("R2 all beats drained", exp_q.size(), 0);
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule